// File: doc/BRIEF.md
# Complement-Checked Monotonic Counter

This block keeps a 32-bit version word that only ever moves forward. The upper half carries a 16-bit count and the lower half carries the bitwise inverse of that count. This makes every stored word self-checking: any word whose halves disagree is detected as corrupt. A word read back from storage is presented through a load strobe. The block validates it and keeps it as the current word. An increment strobe then produces the next word to be written back.

An all-zero word is what erased storage looks like. It is accepted as the starting value, count 0 with inverse 0xFFFF. The count never wraps: once the word reaches 0xFFFF0000, any further increment is refused and a saturated flag is raised. Writing the word to non-volatile storage is left to the surrounding logic.

Top module: `cm_counter`

## Requirements
- R1: After reset the current word is 0x0000FFFF, the valid flag is 1, and both the done pulse and the saturated flag are 0.
- R2: A load of a word whose bits 15:0 equal the bitwise inverse of bits 31:16 makes that word current on the next cycle, with the valid flag at 1.
- R3: A load of 0x00000000 makes the current word 0x0000FFFF on the next cycle, with the valid flag at 1.
- R4: A load of any other word whose halves are not bitwise inverses (for example 0x12341234 or 0xFFFFFFFF) makes the raw word current on the next cycle, with the valid flag at 0.
- R5: An increment on a valid word below the limit adds one to bits 31:16 and subtracts one from bits 15:0. The new word appears one cycle after the request, and the done output is 1 in that same cycle only. Back-to-back requests advance the word once per cycle.
- R6: An increment requested while the word is 0xFFFF0000 leaves the word unchanged and gives no done pulse. It sets the saturated flag on the next cycle. The flag stays set until the next load clears it.
- R7: An increment requested while the valid flag is 0 changes nothing: the word is unchanged, no done pulse occurs, and the saturated flag stays 0.
- R8: When load and increment are requested in the same cycle, the load alone takes effect and no done pulse occurs.
- R9: Whenever the valid flag is 1, bits 15:0 of the current word equal the inverse of bits 31:16, and the count never decreases except through a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Take load_word as the current word this cycle |
| load_word | input | 32 | Word read back from storage |
| inc_req | input | 1 | Request the next word |
| word_q | output | 32 | Current word |
| word_valid | output | 1 | Current word passed the complement check |
| inc_done | output | 1 | One-cycle pulse: the increment was applied |
| at_limit | output | 1 | An increment was refused at the final value |

## Verification
The assertions compare each cycle with the one before it. They therefore assume that reset is held for at least one clock edge before it is released, and that load_en and inc_req are sampled only at rising edges. The bench meets both conditions: it holds reset for several cycles and changes inputs only on falling edges. It never drives X or Z on the strobes after reset. The assertions take no assumption about load_word contents, so the bench feeds both consistent and corrupt words, including the erased and all-ones patterns.

// File: rtl/cm_pkg.sv
package cm_pkg;

    localparam int CNT_W  = 16;
    localparam int WORD_W = 2 * CNT_W;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [WORD_W-1:0] word_t;

    // Upper half: count, lower half: its inverse.
    typedef struct packed {
        cnt_t count;
        cnt_t inverse;
    } cm_word_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_STEP,
        OP_SAT,
        OP_REJECT
    } cm_op_t;

    typedef struct packed {
        cm_word_t word;
        logic     valid;
        logic     sat;
        logic     done;
    } cm_state_t;

    localparam cnt_t CNT_MAX = '1;

    function automatic cm_word_t make_word(input cnt_t c);
        cm_word_t w;
        w.count   = c;
        w.inverse = ~c;
        return w;
    endfunction

    localparam cm_word_t INIT_WORD = '{count: '0, inverse: '1};

endpackage

// File: rtl/cm_check.sv
module cm_check
    import cm_pkg::*;
(
    input  word_t    raw,
    output cm_word_t norm,
    output logic     ok
);
    cm_word_t as_word;
    logic     erased;

    always_comb begin
        as_word = cm_word_t'(raw);
        erased  = (raw == '0);
        norm    = erased ? INIT_WORD : as_word;
        ok      = erased || (as_word.inverse == ~as_word.count);
    end

endmodule

// File: rtl/cm_step.sv
module cm_step
    import cm_pkg::*;
(
    input  cm_word_t cur,
    output cm_word_t nxt,
    output logic     at_top
);
    always_comb begin
        at_top = (cur.count == CNT_MAX);
        nxt    = make_word(cnt_t'(cur.count + 1'b1));
    end

    // R5: the lower half of a consistent word steps down by one
    always_comb begin
        if (!at_top && (cur.inverse == ~cur.count)) begin
            a_r5_lower_dec: assert (nxt.inverse == cnt_t'(cur.inverse - 1'b1))
                else $error("lower half did not decrement");
        end
    end

endmodule

// File: rtl/cm_counter.sv
module cm_counter
    import cm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_en,
    input  logic [31:0] load_word,
    input  logic        inc_req,
    output logic [31:0] word_q,
    output logic        word_valid,
    output logic        inc_done,
    output logic        at_limit
);
    cm_state_t st_q, st_d;
    cm_word_t  load_norm, step_word;
    logic      load_ok, step_top;
    cm_op_t    op;

    cm_check u_check (
        .raw  (load_word),
        .norm (load_norm),
        .ok   (load_ok)
    );

    cm_step u_step (
        .cur    (st_q.word),
        .nxt    (step_word),
        .at_top (step_top)
    );

    // Load wins over increment; increments need a valid word below the limit.
    always_comb begin
        if (load_en)             op = OP_LOAD;
        else if (!inc_req)       op = OP_IDLE;
        else if (!st_q.valid)    op = OP_REJECT;
        else if (step_top)       op = OP_SAT;
        else                     op = OP_STEP;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (op)
            OP_LOAD: begin
                st_d.word  = load_norm;
                st_d.valid = load_ok;
                st_d.sat   = 1'b0;
            end
            OP_STEP: begin
                st_d.word = step_word;
                st_d.done = 1'b1;
            end
            OP_SAT:  st_d.sat = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.word  <= INIT_WORD;
            st_q.valid <= 1'b1;
            st_q.sat   <= 1'b0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q     = st_q.word;
    assign word_valid = st_q.valid;
    assign inc_done   = st_q.done;
    assign at_limit   = st_q.sat;

    // R9: a valid word always has complementary halves
    a_r9_halves_match: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (word_q[15:0] == ~word_q[31:16]));

    // R9: without a load in between, the count never goes backwards
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !load_en && word_valid |=> word_q[31:16] >= $past(word_q[31:16]));

    // R5: a done pulse means the count advanced by exactly one
    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        inc_done |-> word_valid &&
            (word_q[31:16] == $past(word_q[31:16]) + 16'd1));

    // R6: refused increment at the top leaves the word and flags saturation
    a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
        inc_req && !load_en && word_valid && word_q == 32'hFFFF_0000
            |=> at_limit && !inc_done && $stable(word_q));

    // R7: increments on an invalid word do nothing
    a_r7_refused: assert property (@(posedge clk) disable iff (rst)
        inc_req && !load_en && !word_valid
            |=> !inc_done && $stable(word_q) && !word_valid);

    // R8: load beats a simultaneous increment
    a_r8_load_first: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !inc_done && !at_limit);

endmodule

// File: tb/test_cm_counter.sv
module test_cm_counter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [31:0] load_word = '0;
    logic        inc_req = 1'b0;
    logic [31:0] word_q;
    logic        word_valid, inc_done, at_limit;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cm_counter i_cm_counter (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_word  (load_word),
        .inc_req    (inc_req),
        .word_q     (word_q),
        .word_valid (word_valid),
        .inc_done   (inc_done),
        .at_limit   (at_limit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [31:0] w,
                           input logic v, input logic d, input logic s);
        chk({tag, " word"},  word_q, w);
        chk({tag, " valid"}, {31'd0, word_valid}, {31'd0, v});
        chk({tag, " done"},  {31'd0, inc_done},   {31'd0, d});
        chk({tag, " sat"},   {31'd0, at_limit},   {31'd0, s});
    endtask

    // Drive one cycle from a falling edge; results are visible at the next falling edge.
    task automatic cycle(input logic ld, input logic [31:0] w, input logic inc);
        load_en   = ld;
        load_word = w;
        inc_req   = inc;
        @(negedge clk);
        load_en = 1'b0;
        inc_req = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_out("R1 reset", 32'h0000_FFFF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_load_good;
        cycle(1'b1, 32'h1234_EDCB, 1'b0);
        chk_out("R2 load good", 32'h1234_EDCB, 1'b1, 1'b0, 1'b0);
        cycle(1'b0, '0, 1'b1);
        chk_out("R5 step from loaded", 32'h1235_EDCA, 1'b1, 1'b1, 1'b0);
        cycle(1'b0, '0, 1'b0);
        chk_out("R5 done drops", 32'h1235_EDCA, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_erased;
        cycle(1'b1, 32'h0000_0000, 1'b0);
        chk_out("R3 erased", 32'h0000_FFFF, 1'b1, 1'b0, 1'b0);
        load_en = 1'b0;
        inc_req = 1'b1;
        @(negedge clk);
        chk_out("R5 first of pair", 32'h0001_FFFE, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        inc_req = 1'b0;
        chk_out("R5 second of pair", 32'h0002_FFFD, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk_out("R5 pair ends", 32'h0002_FFFD, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_corrupt;
        cycle(1'b1, 32'hFFFF_FFFF, 1'b0);
        chk_out("R4 all ones", 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 32'h1234_1234, 1'b0);
        chk_out("R4 mismatch", 32'h1234_1234, 1'b0, 1'b0, 1'b0);
        cycle(1'b0, '0, 1'b1);
        chk_out("R7 refused inc", 32'h1234_1234, 1'b0, 1'b0, 1'b0);
        cycle(1'b0, '0, 1'b1);
        chk_out("R7 refused again", 32'h1234_1234, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_limit;
        cycle(1'b1, 32'hFFFE_0001, 1'b0);
        chk_out("R2 near top", 32'hFFFE_0001, 1'b1, 1'b0, 1'b0);
        cycle(1'b0, '0, 1'b1);
        chk_out("R5 reach top", 32'hFFFF_0000, 1'b1, 1'b1, 1'b0);
        cycle(1'b0, '0, 1'b1);
        chk_out("R6 saturate", 32'hFFFF_0000, 1'b1, 1'b0, 1'b1);
        cycle(1'b0, '0, 1'b0);
        chk_out("R6 sat sticky", 32'hFFFF_0000, 1'b1, 1'b0, 1'b1);
        cycle(1'b1, 32'h0000_FFFF, 1'b0);
        chk_out("R6 load clears sat", 32'h0000_FFFF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_priority;
        cycle(1'b1, 32'h0005_FFFA, 1'b1);
        chk_out("R8 load wins", 32'h0005_FFFA, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 32'h0000_0000, 1'b1);
        chk_out("R8 erased wins", 32'h0000_FFFF, 1'b1, 1'b0, 1'b0);
        cycle(1'b0, '0, 1'b1);
        chk_out("R9 valid after step", 32'h0001_FFFE, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load_good();
        t_erased();
        t_corrupt();
        t_limit();
        t_priority();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule